// File: doc/BRIEF.md
# Cascaded Three-Controller Interrupt Arbiter

This block gathers twenty-four level-sensitive interrupt lines into one interrupt request to a processor. A master controller takes eight inputs, and two slave controllers take eight inputs each. Each slave's request output can feed one master input. Each controller is set up by a short sequence of initialization bytes and can then be given mask and end-of-interrupt commands. When the processor pulses acknowledge, the arbiter returns an 8-bit vector. The upper bits of the vector come from the base programmed into the controller that won, and the low three bits are the index of the winning input.

A compatibility switch gives the classic two-controller PC arrangement. In that mode the second slave is logically detached, and the request line that sat on its highest-priority input goes straight to master input 5. The first slave stays cascaded on master input 2. Software then programs a master base of 08h and a slave base of 70h.

Top module: `cascade_irq_arbiter`

## Requirements
- R1: Writes go to one controller at a time: wrSel 0 is the master, 1 is slave one and 2 is slave two. A command-port write (wrAddr=0) with bit 4 set starts initialization. That word's bit 1 means single (no cascade word expected) and its bit 0 means a fourth word follows. It clears the mask, in-service and cascade settings. Data-port writes (wrAddr=1) then supply the base word, then the cascade word (only when bit 1 was 0), then the mode word (only when bit 0 was 1). A controller raises no request until its sequence is complete.
- R2: The vector is the base word's bits 7..3 followed by the 3-bit winning input index. Input 0 has the highest priority and input 7 the lowest.
- R3: Master cascade-word bit 2 makes master input 2 follow slave one. Bit 5 makes master input 5 follow slave two. A slave answers an acknowledge only when its own cascade word equals its port number (2 or 5), and it then supplies the vector.
- R4: When pcCompat is 1, slave two raises nothing and master input 5 follows irqIn[16] directly. The vector then comes from the master base with index 5.
- R5: After initialization, a data-port write loads the mask. A set mask bit stops that input from interrupting.
- R6: While an in-service bit is set, requests on that input and on lower-priority inputs are held back. Higher-priority inputs still interrupt.
- R7: A command-port write with bits 4 and 3 clear is an end-of-interrupt command. Bits 7..5 = 001 clear the highest-priority in-service bit. Bits 7..5 = 011 clear the in-service bit whose index is in bits 2..0. A cascaded interrupt needs this command at both the slave and the master.
- R8: An intaReq pulse gives vecValid high with the vector on the next cycle. It also sets the in-service bit of each controller that supplied the winner. vecOut holds its value between acknowledges.
- R9: Mode-word bit 1 selects automatic end of interrupt: the acknowledge sets no in-service bit in that controller.
- R10: If no request is pending at acknowledge, the vector carries index 7 and no in-service bit is set. A cascaded slave with nothing pending returns its own base with index 7.
- R11: Mode-word bit 4 on the master lets a higher request from a slave pass while that slave's master input is already in service.
- R12: ctlEnable bit n gates every request of controller n.
- R13: After reset, intOut and vecValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Target controller: 0 master, 1 slave one, 2 slave two |
| wrAddr | input | 1 | 0 command port, 1 data port |
| wrData | input | 8 | Write byte |
| pcCompat | input | 1 | Detach slave two and route its input 0 to master input 5 |
| ctlEnable | input | 3 | Per-controller request enable |
| irqIn | input | 24 | Request lines, 8 per controller, master in bits 7..0 |
| intaReq | input | 1 | Acknowledge pulse |
| intOut | output | 1 | Interrupt request to the processor |
| vecValid | output | 1 | Vector valid, one cycle after acknowledge |
| vecOut | output | 8 | Interrupt vector |

## Verification
The bench builds the block with its default parameters: 3 index bits, slave one on master input 2 and slave two on master input 5. This gives the exact PC layout, with master base 08h, slave bases 70h and 78h, and the compatibility reroute onto input 5. Nesting, both kinds of end-of-interrupt, automatic end of interrupt and special fully nested mode are reached by re-initializing controllers between phases. The spurious case is produced by dropping a line and then acknowledging.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef struct packed {
    logic       ready;
    logic       icw1;
    logic       icw2;
    logic       icw3;
    logic       icw4;
    logic       ocw1;
    logic       eoiAny;
    logic       eoiSpec;
    logic [7:0] data;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl #(
  parameter int NCTL  = 3,
  parameter int SEL_W = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [SEL_W-1:0]                    wrSel,
  input  logic                                wrAddr,
  input  logic [7:0]                          wrData,
  output irq_arb_pkg::ctlStrobe_t [NCTL-1:0]  strb
);
  typedef enum logic [2:0] {S_UNINIT, S_BASE, S_CAS, S_MODE, S_READY} seqState_t;

  for (genvar g = 0; g < NCTL; g++) begin : g_seq
    seqState_t st;
    logic      singleMode, wantMode;
    logic      hit, isInit, isCmd, isData;

    assign hit    = wrEn && (wrSel == SEL_W'(g));
    assign isInit = hit && !wrAddr && wrData[4];
    assign isCmd  = hit && !wrAddr && !wrData[4] && !wrData[3];
    assign isData = hit && wrAddr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st         <= S_UNINIT;
        singleMode <= 1'b0;
        wantMode   <= 1'b0;
      end else if (isInit) begin
        st         <= S_BASE;
        singleMode <= wrData[1];
        wantMode   <= wrData[0];
      end else if (isData) begin
        case (st)
          S_BASE:  st <= !singleMode ? S_CAS : (wantMode ? S_MODE : S_READY);
          S_CAS:   st <= wantMode ? S_MODE : S_READY;
          S_MODE:  st <= S_READY;
          default: st <= st;
        endcase
      end
    end

    assign strb[g] = '{
      ready:   (st == S_READY),
      icw1:    isInit,
      icw2:    isData && (st == S_BASE),
      icw3:    isData && (st == S_CAS),
      icw4:    isData && (st == S_MODE),
      ocw1:    isData && (st == S_READY),
      eoiAny:  isCmd && (st == S_READY) && (wrData[7:5] == 3'b001),
      eoiSpec: isCmd && (st == S_READY) && (wrData[7:5] == 3'b011),
      data:    wrData
    };
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int IDX_W     = 3,
  parameter bit IS_MASTER = 1'b0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  irq_arb_pkg::ctlStrobe_t   strb,
  input  logic                      en,
  input  logic [(1<<IDX_W)-1:0]     lineIn,
  input  logic                      ackSet,
  output logic                      reqAny,
  output logic [IDX_W-1:0]          winIdx,
  output logic [7-IDX_W:0]          baseOut,
  output logic [(1<<IDX_W)-1:0]     casCfg
);
  localparam int NIN    = 1 << IDX_W;
  localparam int BASE_W = 8 - IDX_W;

  logic [NIN-1:0]    irr, isr, imr, eligible, clrMask, setMask;
  logic [BASE_W-1:0] baseQ;
  logic              autoEoi, nestSpecial, found;

  always_comb begin
    logic above;
    above = 1'b0;
    for (int i = 0; i < NIN; i++) begin
      logic selfBlk;
      selfBlk     = isr[i] && !(IS_MASTER && nestSpecial && casCfg[i]);
      eligible[i] = irr[i] && !imr[i] && !above && !selfBlk;
      above       = above | isr[i];
    end
  end

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = 0; i < NIN; i++) begin
      if (eligible[i] && !found) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  assign reqAny  = strb.ready && en && found;
  assign baseOut = baseQ;

  always_comb begin
    clrMask = '0;
    if (strb.eoiAny)  clrMask = isr & (~isr + NIN'(1));
    if (strb.eoiSpec) clrMask = NIN'(1) << strb.data[IDX_W-1:0];
    setMask = (ackSet && !autoEoi) ? (NIN'(1) << winIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr         <= '0;
      isr         <= '0;
      imr         <= '0;
      casCfg      <= '0;
      baseQ       <= '0;
      autoEoi     <= 1'b0;
      nestSpecial <= 1'b0;
    end else begin
      irr <= en ? lineIn : '0;
      if (strb.icw1) begin
        isr         <= '0;
        imr         <= '0;
        casCfg      <= '0;
        autoEoi     <= 1'b0;
        nestSpecial <= 1'b0;
      end else begin
        isr <= (isr & ~clrMask) | setMask;
        if (strb.icw2) baseQ  <= strb.data[7:IDX_W];
        if (strb.icw3) casCfg <= strb.data[NIN-1:0];
        if (strb.icw4) begin
          autoEoi     <= strb.data[1];
          nestSpecial <= strb.data[4];
        end
        if (strb.ocw1) imr <= strb.data[NIN-1:0];
      end
    end
  end
endmodule

// File: rtl/cascade_irq_arbiter.sv
module cascade_irq_arbiter #(
  parameter int IDX_W   = 3,
  parameter int S1_PORT = 2,
  parameter int S2_PORT = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [1:0]              wrSel,
  input  logic                    wrAddr,
  input  logic [7:0]              wrData,
  input  logic                    pcCompat,
  input  logic [2:0]              ctlEnable,
  input  logic [3*(1<<IDX_W)-1:0] irqIn,
  input  logic                    intaReq,
  output logic                    intOut,
  output logic                    vecValid,
  output logic [7:0]              vecOut
);
  localparam int NIN    = 1 << IDX_W;
  localparam int BASE_W = 8 - IDX_W;
  localparam int NCTL   = 3;

  function automatic logic [IDX_W-1:0] portOf(input int g);
    return (g == 1) ? IDX_W'(S1_PORT) : IDX_W'(S2_PORT);
  endfunction

  irq_arb_pkg::ctlStrobe_t [NCTL-1:0] strbArr;
  logic [NIN-1:0]    lineArr   [NCTL];
  logic [NIN-1:0]    casCfgArr [NCTL];
  logic [BASE_W-1:0] baseArr   [NCTL];
  logic [IDX_W-1:0]  winArr    [NCTL];
  logic [NCTL-1:0]   reqArr, ackSet, enArr, casLive;
  logic [NIN-1:0]    mLine;
  logic [7:0]        vecNext;

  irq_cmd_ctrl #(.NCTL(NCTL), .SEL_W(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrAddr(wrAddr), .wrData(wrData), .strb(strbArr)
  );

  assign enArr[0] = ctlEnable[0];
  assign enArr[1] = ctlEnable[1];
  assign enArr[2] = ctlEnable[2] && !pcCompat;

  always_comb begin
    casLive[0] = 1'b0;
    for (int g = 1; g < NCTL; g++)
      casLive[g] = casCfgArr[0][portOf(g)] && !(g == 2 && pcCompat);
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      mLine[i] = irqIn[i];
      for (int g = 1; g < NCTL; g++)
        if (i == int'(portOf(g)) && casLive[g]) mLine[i] = reqArr[g];
      if (pcCompat && i == S2_PORT) mLine[i] = irqIn[2*NIN];
    end
  end

  for (genvar g = 0; g < NCTL; g++) begin : g_bank
    if (g == 0) begin : g_m
      assign lineArr[g] = mLine;
    end else begin : g_s
      assign lineArr[g] = irqIn[g*NIN +: NIN];
    end
    irq_bank #(.IDX_W(IDX_W), .IS_MASTER(g == 0)) u_bank (
      .clk(clk), .rstN(rstN), .strb(strbArr[g]), .en(enArr[g]),
      .lineIn(lineArr[g]), .ackSet(ackSet[g]), .reqAny(reqArr[g]),
      .winIdx(winArr[g]), .baseOut(baseArr[g]), .casCfg(casCfgArr[g])
    );
  end

  always_comb begin
    ackSet  = '0;
    vecNext = {baseArr[0], {IDX_W{1'b1}}};
    if (reqArr[0]) begin
      ackSet[0] = 1'b1;
      vecNext   = {baseArr[0], winArr[0]};
      for (int g = 1; g < NCTL; g++) begin
        if (winArr[0] == portOf(g) && casLive[g]) begin
          vecNext = {baseArr[g], {IDX_W{1'b1}}};
          if (casCfgArr[g] == NIN'(portOf(g)) && reqArr[g]) begin
            ackSet[g] = 1'b1;
            vecNext   = {baseArr[g], winArr[g]};
          end
        end
      end
    end
    ackSet = ackSet & {NCTL{intaReq}};
  end

  assign intOut = reqArr[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= intaReq;
      if (intaReq) vecOut <= vecNext;
    end
  end
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int IDX_W = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       intaReq,
  input logic       intOut,
  input logic       vecValid,
  input logic [7:0] vecOut,
  input logic       masterEn
);
  p_vec_follows_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    intaReq |=> vecValid);

  p_vec_has_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(intaReq));

  p_vec_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    !intaReq |=> $stable(vecOut));

  p_idle_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intaReq && !intOut) |=> (vecOut[IDX_W-1:0] == {IDX_W{1'b1}}));

  p_enable_gates_r12: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> !intOut);
endmodule

bind cascade_irq_arbiter irq_arb_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .intaReq(intaReq), .intOut(intOut),
  .vecValid(vecValid), .vecOut(vecOut), .masterEn(ctlEnable[0])
);

// File: tb/cascade_irq_arbiter_tb.sv
module cascade_irq_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic        wrAddr = 1'b0;
  logic [7:0]  wrData = '0;
  logic        pcCompat = 1'b0;
  logic [2:0]  ctlEnable = 3'b111;
  logic [23:0] irqIn = '0;
  logic        intaReq = 1'b0;
  logic        intOut, vecValid;
  logic [7:0]  vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_arbiter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .pcCompat(pcCompat), .ctlEnable(ctlEnable), .irqIn(irqIn),
    .intaReq(intaReq), .intOut(intOut), .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input bit addr, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel[1:0]; wrAddr = addr; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic init(input int sel, input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
    wr(sel, 1'b0, 8'h11);
    wr(sel, 1'b1, b);
    wr(sel, 1'b1, c);
    wr(sel, 1'b1, m);
  endtask

  task automatic eoi(input int sel);
    wr(sel, 1'b0, 8'h20);
  endtask

  // driver: push expected vector, then pulse acknowledge
  task automatic ack(input logic [7:0] exp, input string req);
    expQ.push_back(exp);
    tagQ.push_back(req);
    @(negedge clk);
    intaReq = 1'b1;
    @(negedge clk);
    intaReq = 1'b0;
  endtask

  task automatic line(input int idx, input bit v);
    @(negedge clk);
    irqIn[idx] = v;
    waitc(3);
  endtask

  // monitor: compares each delivered vector against the scoreboard
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected vector actual=%0h expected=none", vecOut);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, vecOut, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitc(3);
    check("R13 intOut after reset", intOut, 0);
    check("R13 vecValid after reset", vecValid, 0);
    rstN = 1'b1;
    waitc(2);

    // R1: nothing before initialization
    line(0, 1'b1);
    check("R1 no request before init", intOut, 0);
    line(0, 1'b0);

    init(0, 8'h08, 8'h24, 8'h01);
    init(1, 8'h70, 8'h02, 8'h01);
    init(2, 8'h78, 8'h05, 8'h01);

    // R2: priority and vector
    irqIn[6] = 1'b1;
    line(3, 1'b1);
    check("R2 request seen", intOut, 1);
    ack(8'h0B, "R2 vector IR3 over IR6");
    line(3, 1'b0);
    eoi(0);
    waitc(2);
    ack(8'h0E, "R2 vector IR6");
    line(6, 1'b0);
    eoi(0);

    // R6 / R7 nesting and end of interrupt
    line(4, 1'b1);
    ack(8'h0C, "R6 ack IR4");
    line(6, 1'b1);
    check("R6 lower blocked by in-service", intOut, 0);
    line(1, 1'b1);
    check("R6 higher passes", intOut, 1);
    ack(8'h09, "R6 nested IR1");
    line(1, 1'b0);
    eoi(0);
    waitc(2);
    check("R7 non-specific cleared only IR1", intOut, 0);
    wr(0, 1'b0, 8'h64);
    waitc(2);
    check("R7 specific EOI level 4", intOut, 1);
    line(4, 1'b0);
    ack(8'h0E, "R7 IR6 after EOI");
    line(6, 1'b0);
    eoi(0);

    // R3 cascade through slave one and slave two
    line(11, 1'b1);
    check("R3 slave request reaches master", intOut, 1);
    ack(8'h73, "R3 slave one vector");
    line(11, 1'b0);
    eoi(1);
    line(13, 1'b1);
    check("R7 master still in service", intOut, 0);
    eoi(0);
    waitc(2);
    check("R7 master EOI releases", intOut, 1);
    ack(8'h75, "R3 slave one IR5");
    line(13, 1'b0);
    eoi(1); eoi(0);
    line(18, 1'b1);
    ack(8'h7A, "R3 slave two vector");
    line(18, 1'b0);
    eoi(2); eoi(0);

    // R5 mask
    wr(0, 1'b1, 8'h08);
    line(3, 1'b1);
    check("R5 masked IR3", intOut, 0);
    line(7, 1'b1);
    ack(8'h0F, "R5 unmasked IR7");
    line(7, 1'b0);
    eoi(0);
    wr(0, 1'b1, 8'h00);
    waitc(2);
    check("R5 unmask", intOut, 1);
    ack(8'h0B, "R5 IR3 after unmask");
    line(3, 1'b0);
    eoi(0);

    // R10 spurious
    line(6, 1'b1);
    line(6, 1'b0);
    ack(8'h0F, "R10 spurious vector");
    line(7, 1'b1);
    check("R10 no in-service after spurious", intOut, 1);
    ack(8'h0F, "R10 real IR7");
    line(7, 1'b0);
    eoi(0);

    // R12 enable
    ctlEnable[0] = 1'b0;
    line(1, 1'b1);
    check("R12 disabled master", intOut, 0);
    ctlEnable[0] = 1'b1;
    waitc(3);
    check("R12 enabled master", intOut, 1);
    ack(8'h09, "R12 IR1");
    line(1, 1'b0);
    eoi(0);

    // R9 automatic end of interrupt on slave one
    init(1, 8'h70, 8'h02, 8'h03);
    line(9, 1'b1);
    ack(8'h71, "R9 slave AEOI vector");
    eoi(0);
    waitc(3);
    check("R9 slave not in service", intOut, 1);
    ack(8'h71, "R9 repeat");
    line(9, 1'b0);
    eoi(0);
    waitc(2);
    check("R9 idle", intOut, 0);

    // R11 special fully nested on master
    init(0, 8'h08, 8'h24, 8'h11);
    init(1, 8'h70, 8'h02, 8'h01);
    line(12, 1'b1);
    ack(8'h74, "R11 slave IR4");
    line(10, 1'b1);
    check("R11 higher slave request passes", intOut, 1);
    ack(8'h72, "R11 slave IR2");
    irqIn[10] = 1'b0;
    line(12, 1'b0);
    eoi(1); eoi(1); eoi(0);
    waitc(2);
    check("R11 all cleared", intOut, 0);

    // R4 compatibility layout
    init(0, 8'h08, 8'h04, 8'h01);
    pcCompat = 1'b1;
    line(16, 1'b1);
    ack(8'h0D, "R4 rerouted to master IR5");
    line(16, 1'b0);
    eoi(0);
    line(19, 1'b1);
    check("R4 detached slave silent", intOut, 0);
    line(8, 1'b1);
    ack(8'h70, "R4 slave one still cascaded");
    line(8, 1'b0);
    eoi(1); eoi(0);
    line(19, 1'b0);

    waitc(3);
    check("R8 all vectors delivered", expQ.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule